// File: doc/BRIEF.md
# L1 Data-Cache Maintenance Command Unit

This block is the maintenance front end of a small direct-mapped write-back data cache. Each line is modelled only as a valid bit, a dirty bit and a tag. Software programs a control word that holds a disable bit and an invalidate-mode bit. It then issues commands by writing to command selects on a register write port. The commands either act on the whole cache or on the single line that contains a given address. A walk engine steps through the tag array and offers every dirty line that must be written back on a write-back port. It then cleans or discards the line as the command requires. Software polls a status bit in the control readback until the write-back work has finished.

The invalidate command has two behaviours, chosen by the mode bit. With the bit clear, lines are discarded. With the bit set, dirty lines are written back first and then discarded. A flush writes dirty lines back and leaves them valid and clean. The status bit is set only while a walk that writes back (flush, or invalidate in write-back mode) is running. A plain discard walk keeps the register port busy but leaves the status bit clear. The fill and probe ports stand in for the cache's own allocation and hit lookup.

The register write port and the fill port are valid/ready: while `reg_wready`/`fill_ready` is low (a walk is running), the offered transfer must be held and is applied when ready returns, never dropped. The write-back port is valid/ready the other way: `wb_valid` and `wb_addr` stay constant until `wb_ready` is seen, and the walk stalls on that line meanwhile.

Top module: `dcache_maint_unit`

## Requirements
- R1: After reset every line is invalid and clean, the control readback is 9'h001 (disabled, mode 0, status 0), and `reg_wready` and `fill_ready` are high.
- R2: A write with select 0 loads the disable bit from data bit 0 and the invalidate-mode bit from data bit 6. The readback `ctrl_rd` shows disable at bit 0, mode at bit 6 and status at bit 8, with all other bits 0. The status bit cannot be written.
- R3: While the disable bit is 1, command writes (selects 1 to 4) are accepted and have no effect: no write-back is requested and no line changes.
- R4: A whole-cache flush (select 2, any data) offers every valid dirty line once, in ascending index order. Each such line is left valid and clean. Clean lines are untouched.
- R5: A whole-cache invalidate (select 1, any data) with mode 0 clears every line without any write-back.
- R6: A whole-cache invalidate with mode 1 offers every valid dirty line in ascending index order and then leaves every line invalid.
- R7: A line flush (select 4) or line invalidate (select 3) takes the address from the write data. It acts only on the line at that index and only when the stored tag matches. If the tag does not match, nothing happens, and other lines are never affected.
- R8: The status bit (bit 8) reads 1 from the cycle after a flush or a mode-1 invalidate is accepted until its walk ends, and then reads 0. During a mode-0 invalidate it stays 0.
- R9: `reg_wready` is low while a walk runs. A write offered then, including a control write, is held off, and it takes effect only once `reg_wready` returns high.
- R10: `wb_valid` with `wb_addr` stays stable until `wb_ready` is high, and the walk does not advance meanwhile. Lines that need no write-back take one clock each.
- R11: The line size is 16 << LINE_SEL bytes. Address bits below the line size are dropped from command, fill and probe addresses, and `wb_addr` is line aligned with tag and index. A LINE_SEL that makes the line length zero is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wvalid | input | 1 | Register write offered |
| reg_wready | output | 1 | Register write accepted this cycle (idle) |
| reg_wsel | input | 3 | 0 control, 1 invalidate all, 2 flush all, 3 invalidate line, 4 flush line |
| reg_wdata | input | ADDR_W | Control value or line address |
| ctrl_rd | output | 9 | Control readback: bit0 disable, bit6 mode, bit8 status |
| fill_valid | input | 1 | Allocate a line (cache model stand-in) |
| fill_ready | output | 1 | Fill accepted (idle) |
| fill_addr | input | ADDR_W | Address of the allocated line |
| fill_dirty | input | 1 | Allocated line is dirty |
| probe_addr | input | ADDR_W | Lookup address |
| probe_hit | output | 1 | Lookup hits a valid line |
| probe_dirty | output | 1 | Hit line is dirty |
| wb_valid | output | 1 | Write-back request |
| wb_ready | input | 1 | Memory side accepts the write-back |
| wb_addr | output | ADDR_W | Line-aligned write-back address |

## Verification
On every cycle the assertions check that a pending write-back is held stable until it is accepted, and that a walk step with no write-back advances exactly one index. They also check that an update cleans or discards its line as its kind demands, that fills never meet updates, that the status bit never shows while the register port is ready, that a control write waiting on a busy port leaves the control bits alone, and that a disabled command starts no walk. Only the bench scenarios can show the order and set of write-back addresses, the survival of clean lines and of lines whose tag misses, the offset bits being dropped, and the delayed control write landing once the walk has ended.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL       = 3'd0,
    SEL_INV_ALL    = 3'd1,
    SEL_FLUSH_ALL  = 3'd2,
    SEL_INV_LINE   = 3'd3,
    SEL_FLUSH_LINE = 3'd4
  } reg_sel_e;

  localparam int CTRL_DIS_BIT   = 0;
  localparam int CTRL_IMODE_BIT = 6;
  localparam int CTRL_STAT_BIT  = 8;
  localparam int CTRL_W         = 9;

  typedef struct packed {
    logic whole;      // walk all lines instead of one
    logic wb_dirty;   // write dirty lines back before acting
    logic clr_valid;  // discard hit lines
  } maint_op_t;

  typedef enum logic {ST_IDLE, ST_WALK} walk_state_e;

endpackage

// File: rtl/dcm_ctrl_reg.sv
module dcm_ctrl_reg
  import dcm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFFS   = 5,
  parameter int IDX_W  = 4,
  localparam int TAG_W = ADDR_W - OFFS - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wvalid,
  input  logic [2:0]        wsel,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              idle,
  input  logic              busy_wb,
  output logic              wready,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic              start,
  output maint_op_t         start_op,
  output logic [IDX_W-1:0]  start_idx,
  output logic [TAG_W-1:0]  start_tag
);

  logic dis_q, imode_q;
  logic fire, is_cmd, is_flush;

  assign wready   = idle;
  assign fire     = wvalid && idle;
  assign is_cmd   = (wsel == SEL_INV_ALL) || (wsel == SEL_FLUSH_ALL) ||
                    (wsel == SEL_INV_LINE) || (wsel == SEL_FLUSH_LINE);
  assign is_flush = (wsel == SEL_FLUSH_ALL) || (wsel == SEL_FLUSH_LINE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q   <= 1'b1;
      imode_q <= 1'b0;
    end else if (fire && wsel == SEL_CTRL) begin
      dis_q   <= wdata[CTRL_DIS_BIT];
      imode_q <= wdata[CTRL_IMODE_BIT];
    end
  end

  always_comb begin
    ctrl_rd                 = '0;
    ctrl_rd[CTRL_DIS_BIT]   = dis_q;
    ctrl_rd[CTRL_IMODE_BIT] = imode_q;
    ctrl_rd[CTRL_STAT_BIT]  = busy_wb;
  end

  assign start              = fire && is_cmd && !dis_q;
  assign start_op.whole     = (wsel == SEL_INV_ALL) || (wsel == SEL_FLUSH_ALL);
  assign start_op.wb_dirty  = is_flush || imode_q;
  assign start_op.clr_valid = !is_flush;
  assign start_idx          = wdata[OFFS +: IDX_W];
  assign start_tag          = wdata[ADDR_W-1 -: TAG_W];

  // R3: a command taken while disabled starts no walk
  assert_disabled_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && wready && dis_q && wsel != SEL_CTRL) |=> idle);

  // R8: status is never visible while the port is ready
  assert_status_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_wb |-> !wready);

  // R9: a held-off control write changes nothing
  assert_ctrl_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && !wready) |=> ($stable(dis_q) && $stable(imode_q)));

endmodule

// File: rtl/dcm_tag_array.sv
module dcm_tag_array #(
  parameter int NUM_LINES = 16,
  parameter int TAG_W     = 23,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_we,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_dirty,
  input  logic [IDX_W-1:0] probe_idx,
  input  logic [TAG_W-1:0] probe_tag,
  output logic             probe_hit,
  output logic             probe_dirty,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_clr_valid
);

  logic [NUM_LINES-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        dirty_q[i] <= 1'b0;
        tag_q[i]   <= '0;
      end else if (fill_we && fill_idx == IDX_W'(i)) begin
        valid_q[i] <= 1'b1;
        dirty_q[i] <= fill_dirty;
        tag_q[i]   <= fill_tag;
      end else if (upd_en && upd_idx == IDX_W'(i)) begin
        dirty_q[i] <= 1'b0;
        if (upd_clr_valid) valid_q[i] <= 1'b0;
      end
    end
  end

  assign rd_valid    = valid_q[rd_idx];
  assign rd_dirty    = dirty_q[rd_idx];
  assign rd_tag      = tag_q[rd_idx];
  assign probe_hit   = valid_q[probe_idx] && (tag_q[probe_idx] == probe_tag);
  assign probe_dirty = probe_hit && dirty_q[probe_idx];

  // R5/R6: an invalidating update leaves the line invalid and clean
  assert_inv_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_clr_valid) |=>
      (!valid_q[$past(upd_idx)] && !dirty_q[$past(upd_idx)]));

  // R4: a flushing update keeps validity and cleans the line
  assert_flush_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_clr_valid) |=>
      (valid_q[$past(upd_idx)] == $past(valid_q[upd_idx]) && !dirty_q[$past(upd_idx)]));

  // R9: fills only land while no walk updates the array
  assert_fill_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |-> !upd_en);

endmodule

// File: rtl/dcm_walk_engine.sv
module dcm_walk_engine
  import dcm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_LINES = 16,
  parameter int OFFS      = 5,
  localparam int IDX_W    = $clog2(NUM_LINES),
  localparam int TAG_W    = ADDR_W - OFFS - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  maint_op_t         start_op,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [TAG_W-1:0]  start_tag,
  output logic              idle,
  output logic              busy_wb,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_valid,
  input  logic              rd_dirty,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              upd_en,
  output logic [IDX_W-1:0]  upd_idx,
  output logic              upd_clr_valid,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr
);

  walk_state_e      st_q;
  maint_op_t        op_q;
  logic [IDX_W-1:0] idx_q;
  logic [TAG_W-1:0] tag_q;
  logic walking, hit, need_wb, step, last;

  assign walking = (st_q == ST_WALK);
  assign hit     = rd_valid && (op_q.whole || rd_tag == tag_q);
  assign need_wb = walking && hit && rd_dirty && op_q.wb_dirty;
  assign step    = walking && (!need_wb || wb_ready);
  assign last    = !op_q.whole || (idx_q == IDX_W'(NUM_LINES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      op_q  <= '0;
      idx_q <= '0;
      tag_q <= '0;
    end else if (!walking) begin
      if (start) begin
        st_q  <= ST_WALK;
        op_q  <= start_op;
        tag_q <= start_tag;
        idx_q <= start_op.whole ? '0 : start_idx;
      end
    end else if (step) begin
      if (last) st_q <= ST_IDLE;
      else      idx_q <= idx_q + 1'b1;
    end
  end

  assign idle          = !walking;
  assign busy_wb       = walking && op_q.wb_dirty;
  assign rd_idx        = idx_q;
  assign upd_idx       = idx_q;
  assign upd_clr_valid = op_q.clr_valid;
  assign upd_en        = step && hit && (op_q.clr_valid || (rd_dirty && op_q.wb_dirty));
  assign wb_valid      = need_wb;
  assign wb_addr       = {rd_tag, idx_q, {OFFS{1'b0}}};

  // R10: a stalled request holds its address
  assert_wb_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr)));

  // R10: a step without write-back moves to the next line
  assert_walk_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (walking && !wb_valid && !last) |=> (rd_idx == IDX_W'($past(rd_idx) + 1'b1)));

endmodule

// File: rtl/dcache_maint_unit.sv
module dcache_maint_unit
  import dcm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_LINES = 16,
  parameter int LINE_SEL  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wvalid,
  output logic              reg_wready,
  input  logic [2:0]        reg_wsel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [8:0]        ctrl_rd,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_dirty,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_hit,
  output logic              probe_dirty,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr
);

  localparam int unsigned LINE_BYTES = 32'd16 << LINE_SEL;
  localparam int OFFS  = (LINE_BYTES == 0) ? 4 : $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - OFFS - IDX_W;

  if (LINE_BYTES == 0 || OFFS + IDX_W >= ADDR_W) begin : g_bad_geometry
    $error("line size selector yields an unusable line length");
  end

  logic             idle, busy_wb, start;
  maint_op_t        start_op;
  logic [IDX_W-1:0] start_idx, rd_idx, upd_idx;
  logic [TAG_W-1:0] start_tag, rd_tag;
  logic             rd_valid, rd_dirty, upd_en, upd_clr_valid;

  assign fill_ready = idle;

  dcm_ctrl_reg #(.ADDR_W(ADDR_W), .OFFS(OFFS), .IDX_W(IDX_W)) u_ctrl (
    .clk, .rst_n,
    .wvalid (reg_wvalid), .wsel(reg_wsel), .wdata(reg_wdata),
    .idle, .busy_wb,
    .wready (reg_wready), .ctrl_rd,
    .start, .start_op, .start_idx, .start_tag
  );

  dcm_walk_engine #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES), .OFFS(OFFS)) u_walk (
    .clk, .rst_n,
    .start, .start_op, .start_idx, .start_tag,
    .idle, .busy_wb,
    .rd_idx, .rd_valid, .rd_dirty, .rd_tag,
    .upd_en, .upd_idx, .upd_clr_valid,
    .wb_valid, .wb_ready, .wb_addr
  );

  dcm_tag_array #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
    .clk, .rst_n,
    .fill_we    (fill_valid && idle),
    .fill_idx   (fill_addr[OFFS +: IDX_W]),
    .fill_tag   (fill_addr[ADDR_W-1 -: TAG_W]),
    .fill_dirty,
    .probe_idx  (probe_addr[OFFS +: IDX_W]),
    .probe_tag  (probe_addr[ADDR_W-1 -: TAG_W]),
    .probe_hit, .probe_dirty,
    .rd_idx, .rd_valid, .rd_dirty, .rd_tag,
    .upd_en, .upd_idx, .upd_clr_valid
  );

endmodule

// File: tb/tb_dcache_maint_unit.sv
`timescale 1ns/1ps
module tb_dcache_maint_unit;

  logic        clk = 0, rst_n = 0;
  logic        reg_wvalid = 0, reg_wready;
  logic [2:0]  reg_wsel = 0;
  logic [31:0] reg_wdata = 0;
  logic [8:0]  ctrl_rd;
  logic        fill_valid = 0, fill_ready, fill_dirty = 0;
  logic [31:0] fill_addr = 0, probe_addr = 0, wb_addr;
  logic        probe_hit, probe_dirty, wb_valid, wb_ready = 1;

  dcache_maint_unit dut (.*);

  always #5 clk = ~clk;

  localparam logic [31:0] A = 32'h1000_0020, B = 32'h2000_0100,
                          C = 32'h3000_01E0, D = 32'h1000_0040,
                          X = 32'h5000_0020;

  int checks = 0, fails = 0;
  logic [31:0] wb_log [16];
  int wb_cnt = 0;
  bit bp_slow = 0, prev_stall = 0, done = 0;
  logic [31:0] prev_addr = 0;
  int bp_cnt = 0;
  logic [8:0] rd_after;
  logic ready_after;

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // write-back sink: ready pattern, logging, stall stability (R10)
  always begin
    @(negedge clk);
    bp_cnt++;
    wb_ready = bp_slow ? (bp_cnt % 3 == 2) : 1'b1;
    #1;
    if (prev_stall)
      check(wb_valid && wb_addr == prev_addr, "R10 stalled request stable", wb_addr, prev_addr);
    if (wb_valid && wb_ready && wb_cnt < 16) begin
      wb_log[wb_cnt] = wb_addr;
      wb_cnt++;
    end
    prev_stall = wb_valid && !wb_ready;
    prev_addr  = wb_addr;
  end

  task automatic reg_write(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_wvalid = 1; reg_wsel = sel; reg_wdata = data;
    while (!reg_wready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reg_wvalid = 0;
    #1;
    rd_after = ctrl_rd;
    ready_after = reg_wready;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!reg_wready) @(negedge clk);
  endtask

  task automatic fill(input logic [31:0] addr, input logic dirty);
    @(negedge clk);
    fill_valid = 1; fill_addr = addr; fill_dirty = dirty;
    while (!fill_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic probe_expect(input logic [31:0] addr, input logic hit, input logic dirty, input string what);
    @(negedge clk);
    probe_addr = addr;
    #1;
    check(probe_hit == hit && probe_dirty == dirty, what,
          {30'd0, probe_hit, probe_dirty}, {30'd0, hit, dirty});
  endtask

  task automatic t_reset();
    check(ctrl_rd == 9'h001, "R1 control readback after reset", 32'(ctrl_rd), 32'h001);
    check(reg_wready && fill_ready, "R1 ports ready after reset", {31'd0, reg_wready}, 1);
    probe_expect(32'h0, 0, 0, "R1 line 0 invalid after reset");
    probe_expect(A, 0, 0, "R1 line 1 invalid after reset");
  endtask

  task automatic t_ctrl();
    reg_write(3'd0, 32'h0000_0040);
    check(ctrl_rd == 9'h040, "R2 enable with mode 1", 32'(ctrl_rd), 32'h040);
    reg_write(3'd0, 32'hFFFF_FFFF);
    check(ctrl_rd == 9'h041, "R2 only bits 0 and 6 writable", 32'(ctrl_rd), 32'h041);
    reg_write(3'd0, 32'h0000_0000);
    check(ctrl_rd == 9'h000, "R2 clear control", 32'(ctrl_rd), 32'h000);
  endtask

  task automatic t_flush_all();
    fill(A, 1); fill(B, 1); fill(C, 0);
    wb_cnt = 0; bp_slow = 1;
    reg_write(3'd2, 32'h0);
    check(rd_after[8] == 1'b1, "R8 status set during flush", 32'(rd_after), 32'h100);
    check(ready_after == 1'b0, "R9 port busy during flush", {31'd0, ready_after}, 0);
    wait_idle();
    bp_slow = 0;
    check(ctrl_rd[8] == 1'b0, "R8 status clear after flush", 32'(ctrl_rd), 32'h000);
    check(wb_cnt == 2, "R4 flush write-back count", wb_cnt, 2);
    check(wb_log[0] == A, "R4 first write-back address", wb_log[0], A);
    check(wb_log[1] == B, "R4 second write-back address", wb_log[1], B);
    probe_expect(A, 1, 0, "R4 flushed line valid and clean");
    probe_expect(C, 1, 0, "R4 clean line untouched");
  endtask

  task automatic t_inv_plain();
    fill(A, 1);
    wb_cnt = 0;
    reg_write(3'd1, 32'h0);
    check(rd_after[8] == 1'b0, "R8 status clear on plain invalidate", 32'(rd_after), 32'h000);
    check(ready_after == 1'b0, "R9 port busy during invalidate", {31'd0, ready_after}, 0);
    wait_idle();
    check(wb_cnt == 0, "R5 no write-back on discard", wb_cnt, 0);
    probe_expect(A, 0, 0, "R5 dirty line discarded");
    probe_expect(C, 0, 0, "R5 clean line discarded");
  endtask

  task automatic t_inv_wb();
    reg_write(3'd0, 32'h40);
    fill(A, 1); fill(B, 1); fill(C, 0);
    wb_cnt = 0;
    reg_write(3'd1, 32'h0);
    check(rd_after[8] == 1'b1, "R8 status set on write-back invalidate", 32'(rd_after), 32'h100);
    wait_idle();
    check(wb_cnt == 2 && wb_log[0] == A && wb_log[1] == B, "R6 write-backs before discard",
          wb_log[0], A);
    probe_expect(A, 0, 0, "R6 line A invalid");
    probe_expect(B, 0, 0, "R6 line B invalid");
    probe_expect(C, 0, 0, "R6 line C invalid");
  endtask

  task automatic t_line();
    reg_write(3'd0, 32'h0);
    fill(A, 1); fill(D, 1);
    wb_cnt = 0;
    reg_write(3'd4, A + 32'h1F);
    wait_idle();
    check(wb_cnt == 1 && wb_log[0] == A, "R7 R11 line flush aligned address", wb_log[0], A);
    probe_expect(A, 1, 0, "R7 flushed line clean");
    probe_expect(D, 1, 1, "R7 neighbour line untouched");
    reg_write(3'd3, X);
    wait_idle();
    probe_expect(A, 1, 0, "R7 tag mismatch has no effect");
    reg_write(3'd3, A + 32'h3);
    wait_idle();
    probe_expect(A, 0, 0, "R7 line invalidate clears line");
    probe_expect(D, 1, 1, "R7 other line still dirty");
    check(wb_cnt == 1, "R7 no extra write-back", wb_cnt, 1);
  endtask

  task automatic t_disabled();
    reg_write(3'd0, 32'h1);
    fill(A, 1);
    wb_cnt = 0;
    reg_write(3'd1, 32'h0);
    check(ready_after == 1'b1, "R3 disabled command starts nothing", {31'd0, ready_after}, 1);
    reg_write(3'd2, 32'h0);
    reg_write(3'd3, A);
    wait_idle();
    check(wb_cnt == 0, "R3 no write-back while disabled", wb_cnt, 0);
    probe_expect(A, 1, 1, "R3 line unchanged while disabled");
    reg_write(3'd0, 32'h0);
    reg_write(3'd2, 32'h0);
    wait_idle();
    probe_expect(A, 1, 0, "R3 flush works after enable");
  endtask

  task automatic t_hold();
    reg_write(3'd0, 32'h40);
    fill(A, 1); fill(C, 1);
    bp_slow = 1;
    reg_write(3'd2, 32'h0);
    @(negedge clk);
    reg_wvalid = 1; reg_wsel = 3'd0; reg_wdata = 32'h0;
    #1;
    check(reg_wready == 1'b0, "R9 write held off while busy", {31'd0, reg_wready}, 0);
    check(ctrl_rd[6] == 1'b1, "R9 held control write not applied", 32'(ctrl_rd), 32'h140);
    while (!reg_wready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reg_wvalid = 0;
    bp_slow = 0;
    #1;
    check(ctrl_rd == 9'h000, "R9 held control write applied", 32'(ctrl_rd), 32'h000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ctrl();
    t_flush_all();
    t_inv_plain();
    t_inv_wb();
    t_line();
    t_disabled();
    t_hold();
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", checks);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule